// File: doc/BRIEF.md
# Dual-Channel Timer Capture/Compare Controller

This block puts two capture/compare channels, C and D, on one free-running up-counter. Each channel owns one general register, one output pin (a level plus an output enable) and one event flag. A 4-bit control code per channel picks what the channel does, from one of three families.

- **Output compare.** The pin is driven from a programmed starting level. When the counter reaches the register value, the pin is driven low, driven high or toggled.
- **Input capture from the pin.** The channel's pin input passes through a synchronizer. The chosen edge then copies the counter into the register.
- **Input capture from a neighbouring counter.** Every count-up or count-down pulse of that counter copies the counter into the register.

A per-channel buffer-mode input turns the register into plain storage. In buffer mode the channel has no capture, no compare and no pin drive.

Software loads a register through a write strobe and data bus, and clears a flag by pulsing a clear input. A separate input reports that the neighbouring counter runs at the full system clock. While it is high, neighbour-sourced capture is suppressed.

Top module: `cmpcap_pair`

## Requirements
- R1: While reset is asserted the counter `cnt` is 0. After reset it increases by exactly 1 on every clock edge and wraps from all-ones to 0.
- R2: With control code 4'b0000 or 4'b0100 the channel is a compare register with its pin output disabled (`pin_oe` = 0, `pin_out` unchanged), yet a compare match still sets its flag.
- R3: With a control code whose bit 3 is 0 and bits 1:0 are not 00, `pin_oe` is 1. In the cycle after the control code changes to such a value, `pin_out` equals control bit 2 (the initial level). The pin holds that level until the first compare match.
- R4: A compare match is a cycle in which `cnt` equals the channel register. At the edge that ends it, the flag is set and the pin takes its new level: control bits 1:0 = 01 drive 0, 10 drive 1, 11 toggle. A new initial level loaded in the same cycle takes precedence.
- R5: Codes 4'b1000, 4'b1001 and 4'b101x capture from the channel pin on its rising edge, falling edge or either edge respectively. Edges of the other kind are ignored. A pin change sampled at edge k updates the register at edge k+2 with the counter value held between edges k+1 and k+2, and sets the flag.
- R6: Codes 4'b11xx capture on each clock edge at which `nbr_up` or `nbr_dn` is high. The register receives the counter value held just before that edge, and the flag is set.
- R7: While `nbr_fast` is 1, codes 4'b11xx cause no capture: the register and the flag stay unchanged.
- R8: While a channel's buffer-mode input is 1, the channel makes no capture and no compare flag, drives `pin_oe` = 0 and holds `pin_out`. Its register can still be written.
- R9: A flag, once set, stays set until its clear input is pulsed. A set event in the same cycle as a clear leaves the flag set.
- R10: A register write (`gr_wr_x` high with `gr_wdata`) loads the register at the next edge. A capture in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_c | input | 4 | Control code, channel C |
| ctl_d | input | 4 | Control code, channel D |
| buf_en_c | input | 1 | Buffer mode, channel C |
| buf_en_d | input | 1 | Buffer mode, channel D |
| pin_in_c | input | 1 | Asynchronous pin input, channel C |
| pin_in_d | input | 1 | Asynchronous pin input, channel D |
| nbr_up | input | 1 | Neighbour counter count-up pulse |
| nbr_dn | input | 1 | Neighbour counter count-down pulse |
| nbr_fast | input | 1 | Neighbour counter runs at full system clock |
| gr_wr_c | input | 1 | Register write strobe, channel C |
| gr_wr_d | input | 1 | Register write strobe, channel D |
| gr_wdata | input | 16 | Register write data |
| flag_clr_c | input | 1 | Flag clear pulse, channel C |
| flag_clr_d | input | 1 | Flag clear pulse, channel D |
| cnt | output | 16 | Free-running counter value |
| pin_out_c | output | 1 | Pin level, channel C |
| pin_out_d | output | 1 | Pin level, channel D |
| pin_oe_c | output | 1 | Pin output enable, channel C |
| pin_oe_d | output | 1 | Pin output enable, channel D |
| gr_c | output | 16 | General register, channel C |
| gr_d | output | 16 | General register, channel D |
| flag_c | output | 1 | Capture/compare flag, channel C |
| flag_d | output | 1 | Capture/compare flag, channel D |

## Verification
Compare is driven with all six pin-driving codes and with the disabled code. Pairing each starting level with the opposite or the same action separates the initial-level load from the match action. Running toggle twice separates it from a fixed drive.

Pin capture is driven with single rising and falling transitions under each edge code. Applying the non-selected edge first shows that it is ignored, and the captured value pins down the synchronizer latency.

Neighbour capture is pulsed with up and down events, with the full-clock flag set and clear, and in buffer mode. Same-cycle collisions of capture with clear and of capture with a register write settle the two priorities.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10
  } cap_edge_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PIN  = 2'b01,
    SRC_NBR  = 2'b10
  } cap_src_e;

  typedef struct packed {
    logic      is_cmp;
    logic      oe;
    logic      init_lvl;
    cmp_act_e  act;
    cap_src_e  src;
    cap_edge_e edg;
  } chan_mode_t;

  // Turn the raw control code into the channel's working mode.
  function automatic chan_mode_t decode_mode(input logic [CTL_W-1:0] code,
                                             input logic buf_mode,
                                             input logic nbr_fast);
    chan_mode_t m;
    m.is_cmp   = 1'b0;
    m.oe       = 1'b0;
    m.init_lvl = 1'b0;
    m.act      = ACT_NONE;
    m.src      = SRC_NONE;
    m.edg      = EDGE_RISE;
    if (!buf_mode) begin
      if (!code[3]) begin
        m.is_cmp   = 1'b1;
        m.act      = cmp_act_e'(code[1:0]);
        m.oe       = |code[1:0];
        m.init_lvl = code[2];
      end else if (!code[2]) begin
        m.src = SRC_PIN;
        if (code[1])      m.edg = EDGE_BOTH;
        else if (code[0]) m.edg = EDGE_FALL;
        else              m.edg = EDGE_RISE;
      end else begin
        m.src = nbr_fast ? SRC_NONE : SRC_NBR;
      end
    end
    return m;
  endfunction

  // Pin level after a compare match.
  function automatic logic next_level(input cmp_act_e act, input logic cur);
    logic r;
    case (act)
      ACT_LOW:    r = 1'b0;
      ACT_HIGH:   r = 1'b1;
      ACT_TOGGLE: r = ~cur;
      default:    r = cur;
    endcase
    return r;
  endfunction

  // Whether the detected pin edges satisfy the selected edge kind.
  function automatic logic edge_hit(input cap_edge_e edg, input logic rise,
                                    input logic fall);
    logic r;
    case (edg)
      EDGE_RISE: r = rise;
      EDGE_FALL: r = fall;
      EDGE_BOTH: r = rise | fall;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmpcap_counter.sv
module cmpcap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + ONE;
  end

endmodule

// File: rtl/cmpcap_pin_sync.sv
module cmpcap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_sync,
  output logic rise,
  output logic fall
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= pin_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  assign pin_sync = chain[LAST];
  assign rise     = chain[LAST] & ~prev;
  assign fall     = ~chain[LAST] & prev;

endmodule

// File: rtl/cmpcap_channel.sv
module cmpcap_channel
  import cmpcap_pkg::*;
#(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl,
  input  logic             buf_en,
  input  logic             pin_in,
  input  logic             nbr_pulse,
  input  logic             nbr_fast,
  input  logic [W-1:0]     cnt,
  input  logic             gr_wr,
  input  logic [W-1:0]     gr_wdata,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [W-1:0]     gr,
  output logic             flag,
  output logic             cap_evt,
  output logic             cmp_evt,
  output logic             init_evt
);

  chan_mode_t       mode;
  logic [CTL_W-1:0] ctl_q;
  logic             pin_sync;
  logic             pin_rise;
  logic             pin_fall;
  logic             pin_lvl;
  logic [W-1:0]     gr_q;
  logic             flag_q;

  cmpcap_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  assign mode = decode_mode(ctl, buf_en, nbr_fast);

  // Named events, also observed by the bound checker.
  assign init_evt = mode.is_cmp && mode.oe && (ctl != ctl_q);
  assign cmp_evt  = mode.is_cmp && (cnt == gr_q);
  assign cap_evt  = ((mode.src == SRC_PIN) && edge_hit(mode.edg, pin_rise, pin_fall))
                 || ((mode.src == SRC_NBR) && nbr_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pin_lvl <= 1'b0;
    else if (init_evt)            pin_lvl <= mode.init_lvl;
    else if (cmp_evt && mode.oe)  pin_lvl <= next_level(mode.act, pin_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr_q <= '0;
    else if (cap_evt) gr_q <= cnt;
    else if (gr_wr)   gr_q <= gr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (cap_evt || cmp_evt) flag_q <= 1'b1;
    else if (flag_clr)           flag_q <= 1'b0;
  end

  assign pin_out = pin_lvl;
  assign pin_oe  = mode.oe;
  assign gr      = gr_q;
  assign flag    = flag_q;

  // The synchronized level itself is only consumed through its edges.
  logic unused_sync;
  assign unused_sync = pin_sync;

endmodule

// File: rtl/cmpcap_pair.sv
module cmpcap_pair
  import cmpcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_c,
  input  logic [CTL_W-1:0] ctl_d,
  input  logic             buf_en_c,
  input  logic             buf_en_d,
  input  logic             pin_in_c,
  input  logic             pin_in_d,
  input  logic             nbr_up,
  input  logic             nbr_dn,
  input  logic             nbr_fast,
  input  logic             gr_wr_c,
  input  logic             gr_wr_d,
  input  logic [CNT_W-1:0] gr_wdata,
  input  logic             flag_clr_c,
  input  logic             flag_clr_d,
  output logic [CNT_W-1:0] cnt,
  output logic             pin_out_c,
  output logic             pin_out_d,
  output logic             pin_oe_c,
  output logic             pin_oe_d,
  output logic [CNT_W-1:0] gr_c,
  output logic [CNT_W-1:0] gr_d,
  output logic             flag_c,
  output logic             flag_d
);

  localparam int NCH = 2;

  logic                        nbr_pulse;
  logic [NCH-1:0][CTL_W-1:0]   ctl_a;
  logic [NCH-1:0]              buf_a;
  logic [NCH-1:0]              pin_in_a;
  logic [NCH-1:0]              wr_a;
  logic [NCH-1:0]              clr_a;
  logic [NCH-1:0]              pin_out_a;
  logic [NCH-1:0]              pin_oe_a;
  logic [NCH-1:0][CNT_W-1:0]   gr_a;
  logic [NCH-1:0]              flag_a;
  logic [NCH-1:0]              cap_evt;
  logic [NCH-1:0]              cmp_evt;
  logic [NCH-1:0]              init_evt;

  assign nbr_pulse = nbr_up | nbr_dn;
  assign ctl_a     = {ctl_d, ctl_c};
  assign buf_a     = {buf_en_d, buf_en_c};
  assign pin_in_a  = {pin_in_d, pin_in_c};
  assign wr_a      = {gr_wr_d, gr_wr_c};
  assign clr_a     = {flag_clr_d, flag_clr_c};

  cmpcap_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cmpcap_channel #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl_a[ch]),
      .buf_en    (buf_a[ch]),
      .pin_in    (pin_in_a[ch]),
      .nbr_pulse (nbr_pulse),
      .nbr_fast  (nbr_fast),
      .cnt       (cnt),
      .gr_wr     (wr_a[ch]),
      .gr_wdata  (gr_wdata),
      .flag_clr  (clr_a[ch]),
      .pin_out   (pin_out_a[ch]),
      .pin_oe    (pin_oe_a[ch]),
      .gr        (gr_a[ch]),
      .flag      (flag_a[ch]),
      .cap_evt   (cap_evt[ch]),
      .cmp_evt   (cmp_evt[ch]),
      .init_evt  (init_evt[ch])
    );
  end

  assign pin_out_c = pin_out_a[0];
  assign pin_out_d = pin_out_a[1];
  assign pin_oe_c  = pin_oe_a[0];
  assign pin_oe_d  = pin_oe_a[1];
  assign gr_c      = gr_a[0];
  assign gr_d      = gr_a[1];
  assign flag_c    = flag_a[0];
  assign flag_d    = flag_a[1];

endmodule

// File: rtl/cmpcap_pair_chk.sv
module cmpcap_pair_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0][3:0]    ctl,
  input logic [NCH-1:0]         buf_en,
  input logic                   nbr_fast,
  input logic [NCH-1:0]         flag_clr,
  input logic [NCH-1:0][CW-1:0] gr,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         pin_out,
  input logic [NCH-1:0]         pin_oe,
  input logic [NCH-1:0]         cap_evt,
  input logic [NCH-1:0]         cmp_evt,
  input logic [NCH-1:0]         init_evt
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == CW'($past(cnt) + 1'b1))); // R1

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[i][3] && ctl[i][1:0] == 2'b00) |-> !pin_oe[i]); // R2

    AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      init_evt[i] |=> (pin_out[i] == $past(ctl[i][2]))); // R3

    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_evt[i] && !init_evt[i] && !buf_en[i] && ctl[i][3:0] ==? 4'b0?11)
        |=> (pin_out[i] != $past(pin_out[i]))); // R4

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> (gr[i] == $past(cnt))); // R5

    AST_FAST_NOCAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i][3:2] == 2'b11 && nbr_fast) |-> !cap_evt[i]); // R7

    AST_BUF_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en[i] && !flag[i]) |=> !flag[i]); // R8

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !flag_clr[i]) |=> flag[i]); // R9
  end

endmodule

bind cmpcap_pair cmpcap_pair_chk #(.CW(CNT_W), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt),
  .ctl      (ctl_a),
  .buf_en   (buf_a),
  .nbr_fast (nbr_fast),
  .flag_clr (clr_a),
  .gr       (gr_a),
  .flag     (flag_a),
  .pin_out  (pin_out_a),
  .pin_oe   (pin_oe_a),
  .cap_evt  (cap_evt),
  .cmp_evt  (cmp_evt),
  .init_evt (init_evt)
);

// File: tb/cmpcap_pair_tb.sv
module cmpcap_pair_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctl [2];
  logic        buf_en [2];
  logic        pin [2];
  logic        gr_wr [2];
  logic        clr [2];
  logic        nbr_up = 1'b0;
  logic        nbr_dn = 1'b0;
  logic        nbr_fast = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] cnt_o;
  logic        pin_o [2];
  logic        oe_o [2];
  logic [15:0] gr_o [2];
  logic        flag_o [2];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cmpcap_pair u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_c(ctl[0]), .ctl_d(ctl[1]),
    .buf_en_c(buf_en[0]), .buf_en_d(buf_en[1]),
    .pin_in_c(pin[0]), .pin_in_d(pin[1]),
    .nbr_up(nbr_up), .nbr_dn(nbr_dn), .nbr_fast(nbr_fast),
    .gr_wr_c(gr_wr[0]), .gr_wr_d(gr_wr[1]), .gr_wdata(wdata),
    .flag_clr_c(clr[0]), .flag_clr_d(clr[1]),
    .cnt(cnt_o),
    .pin_out_c(pin_o[0]), .pin_out_d(pin_o[1]),
    .pin_oe_c(oe_o[0]), .pin_oe_d(oe_o[1]),
    .gr_c(gr_o[0]), .gr_d(gr_o[1]),
    .flag_c(flag_o[0]), .flag_d(flag_o[1])
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_gr(input int ch, input logic [15:0] v);
    gr_wr[ch] = 1'b1; wdata = v;
    tick();
    gr_wr[ch] = 1'b0;
  endtask

  task automatic clear_flag(input int ch);
    clr[ch] = 1'b1;
    tick();
    clr[ch] = 1'b0;
  endtask

  task automatic pulse_nbr(input bit dn);
    if (dn) nbr_dn = 1'b1; else nbr_up = 1'b1;
    tick();
    nbr_up = 1'b0; nbr_dn = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1", "cnt in reset", cnt_o, 0);
    for (int ch = 0; ch < 2; ch++) begin
      check_eq("R9", "flag in reset", flag_o[ch], 0);
      check_eq("R10", "gr in reset", gr_o[ch], 0);
      check_eq("R2", "oe in reset", oe_o[ch], 0);
    end
    rst_n = 1'b1;
    tick();
    // Code 0000 with gr=0 matches cnt=0 in the first cycle.
    check_eq("R1", "cnt after first edge", cnt_o, 1);
    check_eq("R2", "flag from disabled-output match", flag_o[0], 1);
    check_eq("R2", "pin stays disabled", oe_o[0], 0);
    check_eq("R2", "pin level unchanged", pin_o[0], 0);
  endtask

  task automatic t_counter();
    logic [15:0] a;
    a = cnt_o;
    for (int k = 1; k <= 5; k++) begin
      tick();
      check_eq("R1", "counter step", cnt_o, 16'(a + 16'(k)));
    end
  endtask

  task automatic t_compare(input int ch, input logic [3:0] code,
                           input logic init, input logic after);
    logic [15:0] tgt;
    clear_flag(ch);
    ctl[ch] = code;
    tick();
    check_eq("R3", "initial level", pin_o[ch], init);
    check_eq("R3", "output enabled", oe_o[ch], 1);
    tgt = 16'(cnt_o + 16'd8);
    write_gr(ch, tgt);
    while (cnt_o != tgt) tick();
    check_eq("R3", "level held before match", pin_o[ch], init);
    check_eq("R4", "no flag before match", flag_o[ch], 0);
    tick();
    check_eq("R4", "pin after match", pin_o[ch], after);
    check_eq("R4", "flag after match", flag_o[ch], 1);
  endtask

  task automatic t_toggle_again(input int ch, input logic exp);
    logic [15:0] tgt;
    clear_flag(ch);
    tgt = 16'(cnt_o + 16'd6);
    write_gr(ch, tgt);
    while (cnt_o != tgt) tick();
    tick();
    check_eq("R4", "second toggle", pin_o[ch], exp);
  endtask

  task automatic t_disabled(input int ch);
    logic p;
    ctl[ch] = 4'b0100;
    tick();
    p = pin_o[ch];
    check_eq("R2", "oe off for 0100", oe_o[ch], 0);
    clear_flag(ch);
    write_gr(ch, 16'(cnt_o + 16'd4));
    repeat (6) tick();
    check_eq("R2", "flag set with output off", flag_o[ch], 1);
    check_eq("R2", "pin unchanged with output off", pin_o[ch], p);
  endtask

  task automatic pin_capture(input int ch, input logic lvl, input bit expect_cap);
    logic [15:0] exp_v;
    logic [15:0] old;
    old = gr_o[ch];
    pin[ch] = lvl;
    tick();
    tick();
    exp_v = cnt_o;
    check_eq("R5", "no capture before sync latency", flag_o[ch], 0);
    tick();
    if (expect_cap) begin
      check_eq("R5", "captured count", gr_o[ch], exp_v);
      check_eq("R5", "capture flag", flag_o[ch], 1);
    end else begin
      tick();
      check_eq("R5", "ignored edge keeps gr", gr_o[ch], old);
      check_eq("R5", "ignored edge no flag", flag_o[ch], 0);
    end
  endtask

  task automatic t_pin_modes(input int ch);
    pin[ch] = 1'b0;
    ctl[ch] = 4'b1000;
    repeat (4) tick();
    clear_flag(ch);
    pin_capture(ch, 1'b0, 0);
    pin_capture(ch, 1'b1, 1);            // rise, code 1000
    ctl[ch] = 4'b1000;
    clear_flag(ch);
    pin_capture(ch, 1'b0, 0);            // fall ignored under 1000
    ctl[ch] = 4'b1001;
    clear_flag(ch);
    pin_capture(ch, 1'b1, 0);            // rise ignored under 1001
    pin_capture(ch, 1'b0, 1);            // fall captured
    ctl[ch] = (ch == 0) ? 4'b1010 : 4'b1011;
    clear_flag(ch);
    pin_capture(ch, 1'b1, 1);            // both: rise
    clear_flag(ch);
    pin_capture(ch, 1'b0, 1);            // both: fall
  endtask

  task automatic t_nbr(input int ch, input logic [3:0] code, input bit dn);
    logic [15:0] exp_v;
    nbr_fast = 1'b0;
    ctl[ch] = code;
    clear_flag(ch);
    exp_v = cnt_o;
    pulse_nbr(dn);
    check_eq("R6", "neighbour capture value", gr_o[ch], exp_v);
    check_eq("R6", "neighbour capture flag", flag_o[ch], 1);
  endtask

  task automatic t_fast(input int ch);
    logic [15:0] old;
    ctl[ch] = 4'b1101;
    nbr_fast = 1'b1;
    clear_flag(ch);
    old = gr_o[ch];
    pulse_nbr(0);
    pulse_nbr(1);
    check_eq("R7", "fast neighbour no capture", gr_o[ch], old);
    check_eq("R7", "fast neighbour no flag", flag_o[ch], 0);
    nbr_fast = 1'b0;
  endtask

  task automatic t_buffer(input int ch);
    logic [15:0] old;
    logic p;
    buf_en[ch] = 1'b1;
    ctl[ch] = 4'b1100;
    clear_flag(ch);
    old = gr_o[ch];
    pulse_nbr(0);
    check_eq("R8", "buffer no capture", gr_o[ch], old);
    check_eq("R8", "buffer no flag", flag_o[ch], 0);
    write_gr(ch, 16'h1234);
    check_eq("R8", "buffer register writable", gr_o[ch], 16'h1234);
    p = pin_o[ch];
    ctl[ch] = 4'b0011;
    tick();
    check_eq("R8", "buffer oe off", oe_o[ch], 0);
    write_gr(ch, 16'(cnt_o + 16'd3));
    repeat (6) tick();
    check_eq("R8", "buffer no compare flag", flag_o[ch], 0);
    check_eq("R8", "buffer pin held", pin_o[ch], p);
    buf_en[ch] = 1'b0;
    ctl[ch] = 4'b1100;
    tick();
  endtask

  task automatic t_flag_prio(input int ch);
    ctl[ch] = 4'b1110;
    clear_flag(ch);
    clr[ch] = 1'b1;
    nbr_up = 1'b1;
    tick();
    clr[ch] = 1'b0;
    nbr_up = 1'b0;
    check_eq("R9", "set beats clear", flag_o[ch], 1);
    repeat (3) tick();
    check_eq("R9", "flag sticky", flag_o[ch], 1);
    clear_flag(ch);
    check_eq("R9", "flag cleared", flag_o[ch], 0);
  endtask

  task automatic t_cap_vs_write(input int ch);
    logic [15:0] exp_v;
    ctl[ch] = 4'b1100;
    tick();
    exp_v = cnt_o;
    nbr_up = 1'b1;
    gr_wr[ch] = 1'b1;
    wdata = 16'hABCD;
    tick();
    nbr_up = 1'b0;
    gr_wr[ch] = 1'b0;
    check_eq("R10", "capture wins over write", gr_o[ch], exp_v);
    write_gr(ch, 16'h5A5A);
    check_eq("R10", "plain write", gr_o[ch], 16'h5A5A);
  endtask

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      ctl[ch] = 4'b0000; buf_en[ch] = 1'b0; pin[ch] = 1'b0;
      gr_wr[ch] = 1'b0; clr[ch] = 1'b0;
    end
    repeat (3) tick();
    t_reset();
    t_counter();
    t_compare(0, 4'b0001, 1'b0, 1'b0);
    t_compare(0, 4'b0110, 1'b1, 1'b1);
    t_compare(0, 4'b0101, 1'b1, 1'b0);
    t_compare(0, 4'b0010, 1'b0, 1'b1);
    t_compare(0, 4'b0111, 1'b1, 1'b0);
    t_compare(1, 4'b0011, 1'b0, 1'b1);
    t_toggle_again(1, 1'b0);
    t_disabled(0);
    t_pin_modes(0);
    t_pin_modes(1);
    t_nbr(0, 4'b1100, 0);
    t_nbr(0, 4'b1111, 1);
    t_nbr(1, 4'b1101, 1);
    t_fast(0);
    t_buffer(0);
    t_flag_prio(1);
    t_cap_vs_write(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule